// File: doc/BRIEF.md
# System Clock and Power-Mode Controller

This block manages the system clock and the low-power states of a small microcontroller core. It runs on the main high-frequency clock. The low-speed oscillator reaches it as a one-cycle tick input. The system clock leaves the block as a clock-enable strobe on the main clock, never as a gated clock. The strobe is high on every cycle for full speed. For a slow mode it follows either the low-speed tick or a power-of-two divider of the main clock. An 8-bit control word selects the clock source, the divider ratio, the low-power state a HALT enters, and whether the serial-interface clock keeps running while idle. The same word reports two read-only oscillator ready flags.

When the CPU issues a HALT, the block leaves the running state. It enters Idle, where the sub-clock and optionally the serial clock stay alive. Otherwise it enters Sleep, where the sub-clock survives only if the watchdog asks for it. In both states the CPU enable and the high-oscillator enable drop. A wake-up pulse returns the block to the running mode that the control word selects. Each oscillator has a ready counter. The high-oscillator counter counts main-clock cycles. The low-oscillator counter counts low-speed ticks. Each counter is cleared whenever its oscillator is disabled.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset the control word reads 0x01: the full-speed select bit (bit 0) is 1 and all other bits, including both ready flags, are 0. The mode code is 0 and cpu_en is 1.
- R2: While running with bit 0 = 1, sys_ce is high on every cycle, ser_ce equals sys_ce and mode_o reads 0 (full speed).
- R3: While running with bit 0 = 0 and slow-select field bits [7:5] = 000 or 001, sys_ce equals lo_tick on every cycle and mode_o reads 1 (sub-clock slow mode).
- R4: While running with bit 0 = 0 and bits [7:5] = c in 2..7, sys_ce pulses for one cycle every 2^(8-c) cycles (c=2 gives 64, c=7 gives 2) and mode_o reads 2 (divided slow mode).
- R5: A new slow-select value takes effect only after the divider's next pulse. The interval already running keeps the old ratio, and every interval after that uses the new ratio.
- R6: A one-cycle halt_req while running with bit 1 = 1 makes mode_o read 3 (Idle) from the next cycle. In Idle, cpu_en, hosc_en and sys_ce are 0 and sub_en is 1.
- R7: A halt_req while running with bit 1 = 0 makes mode_o read 4 (Sleep). In Sleep, cpu_en, hosc_en and sys_ce are 0 and sub_en equals wdt_keep.
- R8: In Idle, ser_ce equals lo_tick when bit 4 = 1 and stays 0 when bit 4 = 0.
- R9: A wake pulse in Idle or Sleep returns mode_o on the next cycle to the running mode given by bits 0 and [7:5]. halt_req outside the running state and wake inside it have no effect.
- R10: The high-oscillator ready flag (bit 2) is 0 while hosc_en is low. It becomes 1 exactly 16 main-clock cycles after hosc_en rises or reset is released.
- R11: The low-oscillator ready flag (bit 3) becomes 1 after 4 lo_tick pulses with sub_en high, and returns to 0 once sub_en is low.
- R12: Writes to bits 2 and 3 are ignored: those bits always show the ready counters, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main high-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read value including ready flags |
| lo_tick | input | 1 | One-cycle pulse per low-speed oscillator period |
| halt_req | input | 1 | HALT request pulse from the CPU |
| wake | input | 1 | Wake-up pulse from any enabled source |
| wdt_keep | input | 1 | Watchdog asks the sub-clock to run in Sleep |
| sys_ce | output | 1 | System clock enable |
| ser_ce | output | 1 | Serial interface clock enable |
| cpu_en | output | 1 | CPU running enable |
| hosc_en | output | 1 | High oscillator enable |
| sub_en | output | 1 | Sub-clock (low oscillator) enable |
| mode_o | output | 3 | Mode code: 0 full, 1 sub slow, 2 divided slow, 3 Idle, 4 Sleep |

## Verification
A corrupted divider count or a wrongly loaded ratio shows up at sys_ce within one slow interval, at most 64 cycles. The strobe spacing is then measured against the power of two that the slow-select field implies. A mode register that goes astray shows up on mode_o, cpu_en and sub_en on the cycle after the halt or wake pulse. A ready counter that does not clear or that stops at the wrong count flips bit 2 or bit 3 of the read value one cycle early or late, measured against the exact count.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_IDLE  = 2'd1,
    PS_SLEEP = 2'd2
  } pstate_t;

  localparam logic [2:0] MODE_FULL  = 3'd0;
  localparam logic [2:0] MODE_SUB   = 3'd1;
  localparam logic [2:0] MODE_DIV   = 3'd2;
  localparam logic [2:0] MODE_IDLE  = 3'd3;
  localparam logic [2:0] MODE_SLEEP = 3'd4;

  typedef struct packed {
    logic [2:0] slowc;
    logic       simidle;
    logic       idlen;
    logic       hlclk;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{slowc: 3'd0, simidle: 1'b0, idlen: 1'b0, hlclk: 1'b1};

endpackage

// File: rtl/cpm_regs.sv
module cpm_regs
  import cpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ctl_t       ctl
);

  ctl_t ctl_q, ctl_d;
  logic unused_ro_bits;

  assign unused_ro_bits = ^wdata[3:2];

  always_comb begin
    ctl_d = ctl_q;
    if (wr) begin
      ctl_d.slowc   = wdata[7:5];
      ctl_d.simidle = wdata[4];
      ctl_d.idlen   = wdata[1];
      ctl_d.hlclk   = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  // R1
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctl_q.hlclk == $past(wdata[0])) && (ctl_q.slowc == $past(wdata[7:5])));

endmodule

// File: rtl/cpm_osc_timer.sv
module cpm_osc_timer #(
  parameter int CNT_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic ready
);

  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] TOP = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                      cnt_d = '0;
    else if (tick && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == TOP);

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready);

  // R11
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(en) && $past(tick));

endmodule

// File: rtl/cpm_divider.sv
module cpm_divider #(
  parameter int MAX_EXP = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic [$clog2(MAX_EXP+1)-1:0] exp_req,
  output logic                       pulse
);

  localparam int EW = $clog2(MAX_EXP + 1);
  localparam int CW = MAX_EXP;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] exp_q, exp_d;

  function automatic logic [CW-1:0] reload(input logic [EW-1:0] e);
    logic [CW:0] full;
    full = (CW+1)'(1) << e;
    return CW'(full - 1'b1);
  endfunction

  assign pulse = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (!run) begin
      cnt_d = '0;
    end else if (pulse) begin
      cnt_d = reload(exp_req);
      exp_d = exp_req;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= EW'(MAX_EXP);
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  // Interval checker: cycles between pulses versus the ratio loaded at the previous pulse
  logic [CW:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (pulse) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse && exp_req != '0 |=> !pulse);

  // R5
  gap_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && seen_q) |-> (gap_q == (((CW+1)'(1) << exp_q) - 1'b1)));

endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import cpm_pkg::*;
#(
  parameter int HTO_CYCLES = 16,
  parameter int LTO_TICKS  = 4,
  parameter int MAX_EXP    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       lo_tick,
  input  logic       halt_req,
  input  logic       wake,
  input  logic       wdt_keep,
  output logic       sys_ce,
  output logic       ser_ce,
  output logic       cpu_en,
  output logic       hosc_en,
  output logic       sub_en,
  output logic [2:0] mode_o
);

  localparam int EW = $clog2(MAX_EXP + 1);

  ctl_t    ctl;
  pstate_t state_q, state_d;
  logic    in_run, in_idle, sub_sel, div_pulse, hto, lto;
  logic [EW-1:0] exp_req;

  cpm_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .ctl   (ctl)
  );

  // Power state: next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN:   if (halt_req) state_d = ctl.idlen ? PS_IDLE : PS_SLEEP;
      PS_IDLE,
      PS_SLEEP: if (wake) state_d = PS_RUN;
      default:  state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  assign in_run  = (state_q == PS_RUN);
  assign in_idle = (state_q == PS_IDLE);
  assign sub_sel = (ctl.slowc[2:1] == 2'b00);

  // Slow code c (2..7) divides by 2^(8-c)
  assign exp_req = sub_sel ? EW'(MAX_EXP) : EW'(4'd8 - {1'b0, ctl.slowc});

  cpm_divider #(.MAX_EXP(MAX_EXP)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_run),
    .exp_req (exp_req),
    .pulse   (div_pulse)
  );

  assign hosc_en = in_run;
  assign cpu_en  = in_run;
  assign sub_en  = (state_q != PS_SLEEP) || wdt_keep;

  cpm_osc_timer #(.CNT_MAX(HTO_CYCLES)) u_hto (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (hosc_en),
    .tick  (1'b1),
    .ready (hto)
  );

  cpm_osc_timer #(.CNT_MAX(LTO_TICKS)) u_lto (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sub_en),
    .tick  (lo_tick),
    .ready (lto)
  );

  always_comb begin
    sys_ce = 1'b0;
    if (in_run) begin
      if (ctl.hlclk)    sys_ce = 1'b1;
      else if (sub_sel) sys_ce = lo_tick;
      else              sys_ce = div_pulse;
    end
  end

  assign ser_ce = in_run ? sys_ce : (in_idle && ctl.simidle && lo_tick);

  always_comb begin
    unique case (state_q)
      PS_IDLE:  mode_o = MODE_IDLE;
      PS_SLEEP: mode_o = MODE_SLEEP;
      default:  mode_o = ctl.hlclk ? MODE_FULL : (sub_sel ? MODE_SUB : MODE_DIV);
    endcase
  end

  assign reg_rdata = {ctl.slowc, ctl.simidle, lto, hto, ctl.idlen, ctl.hlclk};

  // R6
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && halt_req && ctl.idlen) |=> (mode_o == MODE_IDLE));

  // R6
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |-> (!hosc_en && !sys_ce));

  // R7
  sub_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en |-> (mode_o == MODE_SLEEP) && !wdt_keep);

  // R8
  ser_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_IDLE && !ctl.simidle) |-> !ser_ce);

  // R9
  wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_en && wake) |=> cpu_en);

endmodule

// File: tb/sim_clk_pwr_ctrl.sv
module sim_clk_pwr_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       lo_tick = 1'b0;
  logic       halt_req = 1'b0;
  logic       wake = 1'b0;
  logic       wdt_keep = 1'b0;
  logic       sys_ce, ser_ce, cpu_en, hosc_en, sub_en;
  logic [2:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit lo_on = 1'b0;
  int lo_ph = 0;
  localparam int LO_DIV = 5;

  always #5 clk = ~clk;

  clk_pwr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lo_tick(lo_tick), .halt_req(halt_req),
    .wake(wake), .wdt_keep(wdt_keep), .sys_ce(sys_ce), .ser_ce(ser_ce),
    .cpu_en(cpu_en), .hosc_en(hosc_en), .sub_en(sub_en), .mode_o(mode_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: inputs settle 1 ns after the edge, samples taken 3 ns after it
  task automatic cyc();
    @(posedge clk);
    #1;
    lo_tick = lo_on && (lo_ph == 0);
    lo_ph = (lo_ph + 1) % LO_DIV;
    #2;
  endtask

  task automatic write(input logic [7:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 300; i++) begin
      cyc();
      reg_wr = 1'b0;
      if (sys_ce) return;
    end
  endtask

  task automatic gap(output int g);
    g = 0;
    for (int i = 0; i < 300; i++) begin
      cyc();
      reg_wr = 1'b0;
      g++;
      if (sys_ce) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(posedge clk);
    #3;
    check("R1 rdata in reset", reg_rdata, 8'h01);
    rst_n = 1'b1;
    check("R1 rdata after reset", reg_rdata, 8'h01);
    check("R1 mode", mode_o, 0);
    check("R1 cpu_en", cpu_en, 1);

    // R12: writing ones to the ready bits leaves them at the counter values
    write(8'h0D);
    check("R12 ro bits ignored", reg_rdata, 8'h01);
    repeat (14) cyc();
    check("R10 hto before 16", reg_rdata[2], 0);
    cyc();
    check("R10 hto at 16", reg_rdata[2], 1);

    // R2 full speed
    for (int i = 0; i < 20; i++) begin
      cyc();
      check("R2 sys_ce", sys_ce, 1);
      check("R8 ser_ce follows sys_ce", ser_ce, sys_ce);
    end
    check("R2 mode", mode_o, 0);

    // Mode sweep over every slow code and source select
    for (int c = 0; c < 8; c++) begin
      for (int h = 0; h < 2; h++) begin
        write(8'((c << 5) | h));
        check("R2 R3 R4 mode sweep", mode_o, h ? 0 : (c < 2 ? 1 : 2));
      end
    end

    // R3 sub-clock slow mode, both codes
    lo_on = 1'b1;
    for (int c = 0; c < 2; c++) begin
      write(8'(c << 5));
      for (int i = 0; i < 30; i++) begin
        cyc();
        check("R3 sys_ce equals lo_tick", sys_ce, lo_tick);
      end
    end
    check("R11 lto set", reg_rdata[3], 1);

    // R4 divided ratios
    for (int c = 2; c < 8; c++) begin
      write(8'(c << 5));
      wait_pulse();
      gap(g);
      gap(g);
      check("R4 divider gap", g, 1 << (8 - c));
      gap(g);
      check("R4 divider gap repeat", g, 1 << (8 - c));
    end

    // R5 ratio change deferred to the next wrap: /64 -> /2
    write(8'h40);
    wait_pulse(); gap(g);
    reg_wr = 1'b1; reg_wdata = 8'hE0;
    gap(g);
    check("R5 old ratio finishes", g, 64);
    gap(g);
    check("R5 new ratio applied", g, 2);
    // /2 -> /64
    reg_wr = 1'b1; reg_wdata = 8'h40;
    gap(g);
    check("R5 short old ratio finishes", g, 2);
    gap(g);
    check("R5 long new ratio", g, 64);

    // R6 Idle entry, serial clock off
    write(8'h03);
    halt_req = 1'b1; cyc(); halt_req = 1'b0;
    check("R6 mode idle", mode_o, 3);
    check("R6 cpu_en", cpu_en, 0);
    check("R6 hosc_en", hosc_en, 0);
    check("R6 sub_en", sub_en, 1);
    cyc();
    check("R10 hto cleared", reg_rdata[2], 0);
    for (int i = 0; i < 20; i++) begin
      cyc();
      check("R6 sys_ce off", sys_ce, 0);
      check("R8 ser_ce off", ser_ce, 0);
    end
    halt_req = 1'b1; cyc(); halt_req = 1'b0;
    check("R9 halt in idle ignored", mode_o, 3);
    wake = 1'b1; cyc(); wake = 1'b0;
    check("R9 wake to full", mode_o, 0);
    check("R9 sys_ce after wake", sys_ce, 1);
    repeat (15) cyc();
    check("R10 hto before 16 after wake", reg_rdata[2], 0);
    cyc();
    check("R10 hto at 16 after wake", reg_rdata[2], 1);
    wake = 1'b1; cyc(); wake = 1'b0;
    check("R9 wake in run ignored", mode_o, 0);

    // R8 serial clock kept in Idle
    write(8'h13);
    halt_req = 1'b1; cyc(); halt_req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      check("R8 ser_ce equals lo_tick", ser_ce, lo_tick);
      check("R6 sys_ce off idle", sys_ce, 0);
    end
    wake = 1'b1; cyc(); wake = 1'b0;

    // R7 Sleep, watchdog keep-alive
    write(8'h60);
    wdt_keep = 1'b0;
    halt_req = 1'b1; cyc(); halt_req = 1'b0;
    check("R7 mode sleep", mode_o, 4);
    check("R7 sub_en off", sub_en, 0);
    check("R7 cpu_en", cpu_en, 0);
    cyc();
    check("R11 lto cleared", reg_rdata[3], 0);
    wdt_keep = 1'b1; cyc();
    check("R7 sub_en keep", sub_en, 1);
    repeat (30) cyc();
    check("R11 lto set in sleep keep", reg_rdata[3], 1);
    wake = 1'b1; cyc(); wake = 1'b0;
    check("R9 wake to divided", mode_o, 2);
    check("R12 ro bits read", reg_rdata[3:2], 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule